// File: doc/BRIEF.md
# Tag-Waiting Operand Station with Pipelined Execution Unit

This block holds operations for one execution unit of an out-of-order core. The issue side writes an operation into a free slot. Each operation carries an opcode, two operand values, and two producer tags. A tag of zero means the value is already valid. A nonzero tag names the producer the operand is still waiting for. The slot watches the result broadcast bus. When the bus shows a matching tag, the slot takes the broadcast value and clears the tag.

When both tags of a slot are zero, the slot can be sent into a short register pipeline. Each stage of that pipeline carries the tag of its operation, and a zero tag marks an empty stage. The pipeline asks for the result bus one stage before its final stage. It keeps the finished result in the final stage until the bus grants it. A slot stays occupied until its own result is granted, so the slot's tag identity stays unique while the result is in flight. Each slot has a fixed nonzero tag, `BASE_TAG + index`.

By default the unit has two slots and a logic operation set. Setting `ARITH` selects the arithmetic operation set. The arithmetic configuration is normally built with three slots.

Top module: `rs_local_ctrl`

## Requirements
- R1: After reset no slot is occupied: `full` is 0, `bus_req` is 0 and `res_tag` is 0.
- R2: An issue with `iss_valid` high while `full` is 0 goes into the lowest-index free slot. While a slot is free, `iss_tag` shows that slot's tag, `BASE_TAG + index`. `full` rises when every slot is occupied, and `iss_tag` is then 0. An issue while `full` is 1 is ignored.
- R3: A slot with a nonzero operand tag never dispatches. When `cdb_tag` equals that tag, the slot stores `cdb_val` as the operand and clears the tag. A nonmatching broadcast changes nothing.
- R4: If an issue and a broadcast of its missing operand's tag happen in the same cycle, the operand is taken from `cdb_val` and stored as already valid.
- R5: When several slots are ready at the same edge, the lowest-index slot dispatches first.
- R6: The pipeline has `STAGES` stages. The default is 3. An operation issued with both tags zero dispatches at the next edge. `bus_req` rises when the operation reaches stage `STAGES-2`, which is two edges after the issue edge. `res_tag` shows the operation one edge later.
- R7: While `res_tag` is nonzero and `bus_grant` is low, `res_tag`, `res_val` and `bus_req` hold their values. All stages stall.
- R8: A slot stays occupied after it dispatches. It is freed at the edge where `bus_grant` is high and `res_tag` equals its tag.
- R9: With `ARITH`=0, the 2-bit opcode selects 0 AND, 1 OR, 2 XOR, 3 NOT of Vj. With `ARITH`=1 it selects 0 ADD, 1 SUB (Vj-Vk), 2 shift Vj left by Vk[4:0], 3 shift Vj right by Vk[4:0].
- R10: `res_tag` is either 0 (empty) or the tag of one of the unit's slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OPW | Opcode of the issued operation |
| iss_vj | input | DW | First operand value |
| iss_vk | input | DW | Second operand value |
| iss_qj | input | TAGW | Producer tag of first operand, 0 when valid |
| iss_qk | input | TAGW | Producer tag of second operand, 0 when valid |
| iss_tag | output | TAGW | Tag of the slot the next issue will use, 0 when full |
| full | output | 1 | Every slot is occupied |
| cdb_tag | input | TAGW | Broadcast tag, 0 when idle |
| cdb_val | input | DW | Broadcast value |
| bus_req | output | 1 | Request for the result bus |
| bus_grant | input | 1 | Result bus granted to this unit |
| res_tag | output | TAGW | Tag in the final stage, 0 when empty |
| res_val | output | DW | Result in the final stage |

## Verification
Two functions can act in the same cycle. The first pair is the issue write and the bus snoop: an operation can arrive while the broadcast it waits for is already on the bus. The bench provokes this by driving `cdb_tag` and `iss_valid` in the same cycle. It then judges the outcome by the final result value, which must contain the broadcast operand. The second pair is dispatch selection with two slots becoming ready together. One broadcast releases both slots at once. The order and values of the two results show that the lower slot went first. The same scenario holds the first result ungranted. This shows that the pipeline stalls and that both slots stay occupied.

// File: rtl/rs_local_ctrl.sv
module rs_local_ctrl #(
  parameter int NSLOT    = 2,
  parameter int DW       = 32,
  parameter int TAGW     = 5,
  parameter int OPW      = 2,
  parameter int STAGES   = 3,
  parameter int BASE_TAG = 8,
  parameter bit ARITH    = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  input  logic [OPW-1:0]  iss_op,
  input  logic [DW-1:0]   iss_vj,
  input  logic [DW-1:0]   iss_vk,
  input  logic [TAGW-1:0] iss_qj,
  input  logic [TAGW-1:0] iss_qk,
  output logic [TAGW-1:0] iss_tag,
  output logic            full,
  input  logic [TAGW-1:0] cdb_tag,
  input  logic [DW-1:0]   cdb_val,
  output logic            bus_req,
  input  logic            bus_grant,
  output logic [TAGW-1:0] res_tag,
  output logic [DW-1:0]   res_val
);
  localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int LAST = STAGES - 1;

  logic            busy [NSLOT];
  logic            sent [NSLOT];
  logic [OPW-1:0]  op   [NSLOT];
  logic [DW-1:0]   vj   [NSLOT];
  logic [DW-1:0]   vk   [NSLOT];
  logic [TAGW-1:0] qj   [NSLOT];
  logic [TAGW-1:0] qk   [NSLOT];

  logic [TAGW-1:0] st_tag [STAGES];
  logic [DW-1:0]   st_val [STAGES];

  logic          have_free, have_rdy;
  logic [IW-1:0] free_idx, rdy_idx;
  logic          adv, accept, disp;
  logic [DW-1:0] a, b, alu;

  function automatic logic [TAGW-1:0] slot_tag(input int i);
    return TAGW'(BASE_TAG + i);
  endfunction

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    have_rdy  = 1'b0;
    rdy_idx   = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        have_free = 1'b1;
        free_idx  = IW'(i);
      end
      if (busy[i] && !sent[i] && qj[i] == '0 && qk[i] == '0) begin
        have_rdy = 1'b1;
        rdy_idx  = IW'(i);
      end
    end
  end

  assign full    = !have_free;
  assign iss_tag = have_free ? TAGW'(BASE_TAG + int'(free_idx)) : '0;
  assign adv     = (st_tag[LAST] == '0) || bus_grant;
  assign accept  = iss_valid && have_free;
  assign disp    = adv && have_rdy;
  assign a       = vj[rdy_idx];
  assign b       = vk[rdy_idx];

  generate
    if (ARITH) begin : g_arith
      always_comb begin
        case (op[rdy_idx])
          2'd0:    alu = a + b;
          2'd1:    alu = a - b;
          2'd2:    alu = a << b[4:0];
          default: alu = a >> b[4:0];
        endcase
      end
    end else begin : g_logic
      always_comb begin
        case (op[rdy_idx])
          2'd0:    alu = a & b;
          2'd1:    alu = a | b;
          2'd2:    alu = a ^ b;
          default: alu = ~a;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSLOT; i++) begin
      if (!rst_n) begin
        busy[i] <= 1'b0;
        sent[i] <= 1'b0;
        op[i]   <= '0;
        vj[i]   <= '0;
        vk[i]   <= '0;
        qj[i]   <= '0;
        qk[i]   <= '0;
      end else if (accept && free_idx == IW'(i)) begin
        busy[i] <= 1'b1;
        sent[i] <= 1'b0;
        op[i]   <= iss_op;
        if (iss_qj != '0 && iss_qj == cdb_tag) begin
          vj[i] <= cdb_val;
          qj[i] <= '0;
        end else begin
          vj[i] <= iss_vj;
          qj[i] <= iss_qj;
        end
        if (iss_qk != '0 && iss_qk == cdb_tag) begin
          vk[i] <= cdb_val;
          qk[i] <= '0;
        end else begin
          vk[i] <= iss_vk;
          qk[i] <= iss_qk;
        end
      end else begin
        if (busy[i] && qj[i] != '0 && qj[i] == cdb_tag) begin
          vj[i] <= cdb_val;
          qj[i] <= '0;
        end
        if (busy[i] && qk[i] != '0 && qk[i] == cdb_tag) begin
          vk[i] <= cdb_val;
          qk[i] <= '0;
        end
        if (disp && rdy_idx == IW'(i)) sent[i] <= 1'b1;
        if (bus_grant && st_tag[LAST] == slot_tag(i)) begin
          busy[i] <= 1'b0;
          sent[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        st_tag[s] <= '0;
        st_val[s] <= '0;
      end
    end else if (adv) begin
      st_tag[0] <= disp ? TAGW'(BASE_TAG + int'(rdy_idx)) : '0;
      st_val[0] <= disp ? alu : '0;
      for (int s = 1; s < STAGES; s++) begin
        st_tag[s] <= st_tag[s-1];
        st_val[s] <= st_val[s-1];
      end
    end
  end

  assign bus_req = (st_tag[LAST-1] != '0) || (st_tag[LAST] != '0);
  assign res_tag = st_tag[LAST];
  assign res_val = st_val[LAST];
endmodule

// File: rtl/rs_local_ctrl_chk.sv
module rs_local_ctrl_chk #(
  parameter int NSLOT    = 2,
  parameter int DW       = 32,
  parameter int TAGW     = 5,
  parameter int BASE_TAG = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            full,
  input logic            bus_req,
  input logic            bus_grant,
  input logic [TAGW-1:0] res_tag,
  input logic [DW-1:0]   res_val
);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_tag != '0 && !bus_grant) |=> ($stable(res_tag) && $stable(res_val)));

  // R6
  req_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_tag != '0) |-> bus_req);

  // R8
  full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !bus_grant) |=> full);

  // R10
  res_tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_tag == '0) || (int'(res_tag) >= BASE_TAG && int'(res_tag) < BASE_TAG + NSLOT));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (res_tag == '0 && !bus_req && !full));
endmodule

bind rs_local_ctrl rs_local_ctrl_chk #(
  .NSLOT(NSLOT), .DW(DW), .TAGW(TAGW), .BASE_TAG(BASE_TAG)
) chk_i (
  .clk(clk), .rst_n(rst_n), .full(full), .bus_req(bus_req),
  .bus_grant(bus_grant), .res_tag(res_tag), .res_val(res_val)
);

// File: tb/rs_local_ctrl_tb_top.sv
module rs_local_ctrl_tb_top;
  localparam int DW = 32;
  localparam int TW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss_valid = 1'b0;
  logic [1:0]    iss_op = '0;
  logic [DW-1:0] iss_vj = '0, iss_vk = '0;
  logic [TW-1:0] iss_qj = '0, iss_qk = '0;
  logic [TW-1:0] iss_tag;
  logic          full;
  logic [TW-1:0] cdb_tag = '0;
  logic [DW-1:0] cdb_val = '0;
  logic          bus_req;
  logic          bus_grant = 1'b0;
  logic [TW-1:0] res_tag;
  logic [DW-1:0] res_val;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rs_local_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_vj(iss_vj), .iss_vk(iss_vk), .iss_qj(iss_qj), .iss_qk(iss_qk),
    .iss_tag(iss_tag), .full(full), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
    .bus_req(bus_req), .bus_grant(bus_grant), .res_tag(res_tag), .res_val(res_val)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [DW-1:0] vj, input logic [DW-1:0] vk,
                       input logic [TW-1:0] qj, input logic [TW-1:0] qk,
                       input logic [TW-1:0] ctag, input logic [DW-1:0] cval);
    @(negedge clk);
    iss_valid = 1'b1; iss_op = op; iss_vj = vj; iss_vk = vk; iss_qj = qj; iss_qk = qk;
    cdb_tag = ctag; cdb_val = cval;
    @(negedge clk);
    iss_valid = 1'b0; iss_qj = '0; iss_qk = '0; cdb_tag = '0; cdb_val = '0;
  endtask

  task automatic broadcast(input logic [TW-1:0] t, input logic [DW-1:0] v);
    cdb_tag = t; cdb_val = v;
    @(negedge clk);
    cdb_tag = '0; cdb_val = '0;
  endtask

  task automatic grant();
    bus_grant = 1'b1;
    @(negedge clk);
    bus_grant = 1'b0;
  endtask

  task automatic collect(input logic [TW-1:0] et, input logic [DW-1:0] ev, input string req);
    int n = 0;
    while (res_tag == '0 && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(res_tag == et, req, res_tag, et);
    chk(res_val == ev, req, res_val, ev);
    grant();
  endtask

  task automatic t_reset();
    chk(full == 1'b0, "R1", full, 0);
    chk(bus_req == 1'b0, "R1", bus_req, 0);
    chk(res_tag == '0, "R1", res_tag, 0);
    chk(iss_tag == TW'(8), "R2", iss_tag, 8);
  endtask

  task automatic t_timing();
    issue(2'd0, 32'h0000F0F0, 32'h0000FF00, '0, '0, '0, '0);
    chk(bus_req == 1'b0, "R6", bus_req, 0);
    chk(iss_tag == TW'(9), "R2", iss_tag, 9);
    @(negedge clk);
    chk(bus_req == 1'b0, "R6", bus_req, 0);
    @(negedge clk);
    chk(bus_req == 1'b1, "R6", bus_req, 1);
    chk(res_tag == '0, "R6", res_tag, 0);
    @(negedge clk);
    chk(res_tag == TW'(8), "R6", res_tag, 8);
    chk(res_val == 32'h0000F000, "R9", res_val, 32'h0000F000);
    chk(iss_tag == TW'(9), "R8", iss_tag, 9);
    grant();
    chk(res_tag == '0, "R10", res_tag, 0);
    chk(bus_req == 1'b0, "R8", bus_req, 0);
    chk(iss_tag == TW'(8), "R8", iss_tag, 8);
  endtask

  task automatic t_wait();
    issue(2'd1, 32'h0, 32'h0F, TW'(5), '0, '0, '0);
    repeat (4) @(negedge clk);
    chk(bus_req == 1'b0, "R3", bus_req, 0);
    broadcast(TW'(6), 32'hFFFF);
    repeat (3) @(negedge clk);
    chk(bus_req == 1'b0, "R3", bus_req, 0);
    broadcast(TW'(5), 32'h30);
    collect(TW'(8), 32'h3F, "R3");
  endtask

  task automatic t_same_cycle();
    issue(2'd2, 32'hAA, 32'h0, '0, TW'(7), TW'(7), 32'h0F);
    collect(TW'(8), 32'hA5, "R4");
  endtask

  task automatic t_full_priority();
    issue(2'd0, 32'h0, 32'hFF, TW'(3), '0, '0, '0);
    issue(2'd1, 32'h0, 32'h01, TW'(3), '0, '0, '0);
    chk(full == 1'b1, "R2", full, 1);
    chk(iss_tag == '0, "R2", iss_tag, 0);
    issue(2'd3, 32'h1234, 32'h0, '0, '0, '0, '0);
    broadcast(TW'(3), 32'h0C);
    repeat (3) @(negedge clk);
    chk(res_tag == TW'(8), "R5", res_tag, 8);
    chk(res_val == 32'h0C, "R5", res_val, 32'h0C);
    repeat (3) @(negedge clk);
    chk(res_tag == TW'(8), "R7", res_tag, 8);
    chk(res_val == 32'h0C, "R7", res_val, 32'h0C);
    chk(bus_req == 1'b1, "R7", bus_req, 1);
    chk(full == 1'b1, "R8", full, 1);
    grant();
    chk(full == 1'b0, "R8", full, 0);
    collect(TW'(9), 32'h0D, "R5");
    repeat (6) begin
      @(negedge clk);
      chk(bus_req == 1'b0 && res_tag == '0, "R2", res_tag, 0);
    end
    chk(full == 1'b0, "R2", full, 0);
  endtask

  task automatic t_ops();
    issue(2'd3, 32'h0000FFFF, 32'h0, '0, '0, '0, '0);
    collect(TW'(8), 32'hFFFF0000, "R9");
    issue(2'd2, 32'hF0F0F0F0, 32'hFF00FF00, '0, '0, '0, '0);
    collect(TW'(8), 32'h0FF00FF0, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_wait();
    t_same_cycle();
    t_full_priority();
    t_ops();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule